// File: doc/BRIEF.md
# Predicated Vector Tail Element Picker

This unit takes one vector register value, a predicate that holds one bit for each byte of that vector, and a two-bit element-size code. It finds the highest-numbered active element under the predicate. A mode input then picks either the element that follows it or that element itself. The picked element is zero-extended into a scalar result and handed to a scalar register file, together with a destination index and a write-enable.

The vector length is a build-time parameter. Element count, predicate width and index widths are derived from it. The design accepts one request per cycle. A request is taken when `startValid` is high, and its result appears on the registered outputs exactly one clock later with a one-cycle `resValid` pulse. Destination index 31 names a hard-wired zero register, so the result for that index is produced but not written.

Top module: `vec_tail_pick`

## Requirements
- R1: The size code gives the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. `resWide` is 1 only for code 3 (a 64-bit scalar result) and is 0 for a 32-bit scalar result.
- R2: Element i of width E bytes is active exactly when predicate bit i*E (the bit of its lowest-addressed byte) is set. The predicate bits of the element's other bytes have no effect.
- R3: With `pickLast`=0 and at least one active element, the chosen element is the last active index plus one.
- R4: With `pickLast`=0, if the last active element is the final element (index count-1), the choice wraps to element 0.
- R5: With `pickLast`=0 and no active element, element 0 is chosen.
- R6: With `pickLast`=1 and at least one active element, the last active element itself is chosen.
- R7: With `pickLast`=1 and no active element, the final element (index count-1) is chosen.
- R8: `resData` holds the chosen element in its low bits. Every bit above the element width is zero, so bits 63:32 are zero whenever `resWide` is 0.
- R9: `resWrEn` is 1 for destination indices 0 to 30. For index 31 it is 0, and `resDest` echoes the requested index.
- R10: Outputs change one clock after a cycle with `startValid` high. `resValid` is high only in that cycle, and `resWrEn` is never high while `resValid` is low.
- R11: After reset, `resValid` and `resWrEn` are 0 and `resData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request strobe, inputs sampled when high |
| vecIn | input | VLEN | Source vector value, byte 0 in bits 7:0 |
| predIn | input | VLEN/8 | Predicate, one bit per vector byte |
| sizeCode | input | 2 | Element size code (0=8, 1=16, 2=32, 3=64 bits) |
| pickLast | input | 1 | 0 picks the element after the last active one, 1 picks the last active one |
| destIdx | input | 5 | Scalar destination index, 31 is the zero register |
| resValid | output | 1 | One-cycle result pulse |
| resData | output | 64 | Zero-extended picked element |
| resWide | output | 1 | 1 when the result is 64 bits wide, 0 for 32 bits |
| resWrEn | output | 1 | Write-enable toward the scalar register file |
| resDest | output | 5 | Destination index of the result |

## Verification
The bench builds the unit with its default 256-bit vector, so the predicate is 32 bits wide. Element counts of 32, 16, 8 and 4 are all in use, which puts the wrap from the final lane, the empty-predicate fallbacks and the ignored upper predicate bits within reach at every size. Each vector byte holds a distinct value with its top bit set, so a wrong lane or a missing zero-extension mask shows up directly in `resData`.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic      load;
    logic      pickLast;
    elemSize_e size;
  } ctrl_t;

  localparam int NUM_SIZES = 4;
  localparam int DEST_W    = 5;
  localparam int RES_W     = 64;

endpackage

// File: rtl/vtp_scan.sv
module vtp_scan #(
  parameter int LANES = 32,
  parameter int IDXW  = 5
) (
  input  logic [LANES-1:0] laneAct,
  output logic [IDXW-1:0]  hiIdx,
  output logic             noneAct
);

  always_comb begin
    hiIdx   = '0;
    noneAct = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (laneAct[i]) begin
        hiIdx   = IDXW'(i);
        noneAct = 1'b0;
      end
    end
  end

endmodule

// File: rtl/vtp_ctrl.sv
module vtp_ctrl
  import vtp_pkg::*;
#(
  parameter int ZERO_IDX = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        sizeCode,
  input  logic              pickLast,
  input  logic [DEST_W-1:0] destIdx,
  output ctrl_t             ctrl,
  output logic              resValid,
  output logic              resWrEn,
  output logic              resWide,
  output logic [DEST_W-1:0] resDest
);

  logic takeWrite;

  always_comb begin
    ctrl.load     = startValid;
    ctrl.pickLast = pickLast;
    ctrl.size     = elemSize_e'(sizeCode);
    takeWrite     = startValid && (destIdx != DEST_W'(ZERO_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resWrEn  <= 1'b0;
      resWide  <= 1'b0;
      resDest  <= '0;
    end else begin
      resValid <= startValid;
      resWrEn  <= takeWrite;
      if (startValid) begin
        resDest <= destIdx;
        resWide <= (elemSize_e'(sizeCode) == SZ_DBL);
      end
    end
  end

endmodule

// File: rtl/vtp_dpath.sv
module vtp_dpath
  import vtp_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [VLEN-1:0]  vecIn,
  input  logic [VLEN/8-1:0] predIn,
  output logic [RES_W-1:0] resData
);

  localparam int PBITS = VLEN / 8;
  localparam int IDXW  = (PBITS > 1) ? $clog2(PBITS) : 1;
  localparam int CNTW  = IDXW + 1;
  localparam int SHW   = IDXW + 3;

  logic [IDXW-1:0] hiArr   [NUM_SIZES];
  logic            noneArr [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LN = PBITS >> s;
    logic [LN-1:0] laneAct;
    for (genvar i = 0; i < LN; i++) begin : g_lane
      assign laneAct[i] = predIn[i << s];
    end
    vtp_scan #(.LANES(LN), .IDXW(IDXW)) u_scan (
      .laneAct(laneAct),
      .hiIdx  (hiArr[s]),
      .noneAct(noneArr[s])
    );
  end

  logic [IDXW-1:0]  hit;
  logic             none;
  logic [CNTW-1:0]  elemCnt;
  logic [CNTW-1:0]  nextIdx;
  logic [CNTW-1:0]  selIdx;
  logic [IDXW-1:0]  byteOff;
  logic [SHW-1:0]   bitOff;
  logic [VLEN-1:0]  shifted;
  logic [RES_W-1:0] keepMask;
  logic [RES_W-1:0] picked;

  always_comb begin
    hit     = hiArr[ctrl.size];
    none    = noneArr[ctrl.size];
    elemCnt = CNTW'(PBITS >> ctrl.size);
    nextIdx = {1'b0, hit} + CNTW'(1);
    if (ctrl.pickLast) begin
      selIdx = none ? (elemCnt - CNTW'(1)) : {1'b0, hit};
    end else begin
      selIdx = (none || (nextIdx == elemCnt)) ? '0 : nextIdx;
    end
    byteOff = IDXW'(selIdx << ctrl.size);
    bitOff  = {byteOff, 3'b000};
    shifted = vecIn >> bitOff;
    unique case (ctrl.size)
      SZ_BYTE: keepMask = 64'h0000_0000_0000_00FF;
      SZ_HALF: keepMask = 64'h0000_0000_0000_FFFF;
      SZ_WORD: keepMask = 64'h0000_0000_FFFF_FFFF;
      default: keepMask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    picked = shifted[RES_W-1:0] & keepMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
    end else if (ctrl.load) begin
      resData <= picked;
    end
  end

endmodule

// File: rtl/vec_tail_pick.sv
module vec_tail_pick
  import vtp_pkg::*;
#(
  parameter int VLEN     = 256,
  parameter int ZERO_IDX = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [VLEN-1:0]   vecIn,
  input  logic [VLEN/8-1:0] predIn,
  input  logic [1:0]        sizeCode,
  input  logic              pickLast,
  input  logic [DEST_W-1:0] destIdx,
  output logic              resValid,
  output logic [RES_W-1:0]  resData,
  output logic              resWide,
  output logic              resWrEn,
  output logic [DEST_W-1:0] resDest
);

  ctrl_t ctrl;

  vtp_ctrl #(.ZERO_IDX(ZERO_IDX)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .sizeCode  (sizeCode),
    .pickLast  (pickLast),
    .destIdx   (destIdx),
    .ctrl      (ctrl),
    .resValid  (resValid),
    .resWrEn   (resWrEn),
    .resWide   (resWide),
    .resDest   (resDest)
  );

  vtp_dpath #(.VLEN(VLEN)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .vecIn  (vecIn),
    .predIn (predIn),
    .resData(resData)
  );

endmodule

// File: rtl/vtp_checker.sv
module vtp_checker
  import vtp_pkg::*;
#(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [VLEN-1:0]   vecIn,
  input logic [VLEN/8-1:0] predIn,
  input logic [1:0]        sizeCode,
  input logic              pickLast,
  input logic [DEST_W-1:0] destIdx,
  input logic              resValid,
  input logic [RES_W-1:0]  resData,
  input logic              resWide,
  input logic              resWrEn,
  input logic [DEST_W-1:0] resDest
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> resValid);

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> !resValid);

  a_r10_wren_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    resWrEn |-> resValid);

  a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rstN)
    resWrEn |-> (resDest != DEST_W'(31)));

  a_r9_write_taken: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && destIdx != DEST_W'(31)) |=> (resWrEn && resDest == $past(destIdx)));

  a_r1_wide_flag: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (resWide == ($past(sizeCode) == 2'd3)));

  a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resWide) |-> (resData[63:32] == 32'd0));

  a_r8_byte_extend: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && sizeCode == 2'd0) |=> (resData[63:8] == 56'd0));

  a_r5_after_empty: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !pickLast && predIn == '0 && sizeCode == 2'd0)
      |=> (resData[7:0] == $past(vecIn[7:0])));

  a_r7_last_empty: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && pickLast && predIn == '0 && sizeCode == 2'd0)
      |=> (resData[7:0] == $past(vecIn[VLEN-1 -: 8])));

endmodule

bind vec_tail_pick vtp_checker #(.VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .vecIn     (vecIn),
  .predIn    (predIn),
  .sizeCode  (sizeCode),
  .pickLast  (pickLast),
  .destIdx   (destIdx),
  .resValid  (resValid),
  .resData   (resData),
  .resWide   (resWide),
  .resWrEn   (resWrEn),
  .resDest   (resDest)
);

// File: tb/test_vec_tail_pick.sv
module test_vec_tail_pick;

  localparam int VLEN   = 256;
  localparam int PBITS  = VLEN / 8;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              startValid;
  logic [VLEN-1:0]   vecIn;
  logic [PBITS-1:0]  predIn;
  logic [1:0]        sizeCode;
  logic              pickLast;
  logic [4:0]        destIdx;
  logic              resValid;
  logic [63:0]       resData;
  logic              resWide;
  logic              resWrEn;
  logic [4:0]        resDest;

  int nChecks = 0;
  int nBad    = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_tail_pick #(.VLEN(VLEN)) i_vec_tail_pick (
    .clk(clk), .rstN(rstN), .startValid(startValid), .vecIn(vecIn),
    .predIn(predIn), .sizeCode(sizeCode), .pickLast(pickLast),
    .destIdx(destIdx), .resValid(resValid), .resData(resData),
    .resWide(resWide), .resWrEn(resWrEn), .resDest(resDest)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int sz, input bit last,
                                        input logic [PBITS-1:0] pr,
                                        input logic [VLEN-1:0] v);
    int ebytes = 1 << sz;
    int cnt    = PBITS / ebytes;
    int lastAct = -1;
    int pick;
    logic [63:0] val;
    for (int e = 0; e < cnt; e++) if (pr[e * ebytes]) lastAct = e;
    if (last) pick = (lastAct < 0) ? cnt - 1 : lastAct;
    else      pick = (lastAct < 0 || lastAct == cnt - 1) ? 0 : lastAct + 1;
    val = '0;
    for (int b = 0; b < ebytes; b++) val[b*8 +: 8] = v[(pick*ebytes + b)*8 +: 8];
    return val;
  endfunction

  task automatic runCase(input int sz, input bit last, input logic [PBITS-1:0] pr,
                         input logic [4:0] dst, input string req);
    logic [63:0] exp;
    exp = model(sz, last, pr, vecIn);
    @(negedge clk);
    startValid = 1'b1;
    sizeCode   = 2'(sz);
    pickLast   = last;
    predIn     = pr;
    destIdx    = dst;
    @(negedge clk);
    startValid = 1'b0;
    chk(resData == exp, req, resData, exp);
    chk(resValid == 1'b1, "R10 valid pulse", 64'(resValid), 64'd1);
    chk(resWide == (sz == 3), "R1 wide flag", 64'(resWide), 64'(sz == 3));
    chk(resWrEn == (dst != 5'd31), "R9 write enable", 64'(resWrEn), 64'(dst != 5'd31));
    chk(resDest == dst, "R9 dest echo", 64'(resDest), 64'(dst));
    if (sz < 3) chk(resData[63:32] == 32'd0, "R8 upper zero", resData, exp);
    @(negedge clk);
    chk(resValid == 1'b0 && resWrEn == 1'b0, "R10 single cycle",
        64'({resValid, resWrEn}), 64'd0);
  endtask

  task automatic tReset();
    chk(resValid == 1'b0, "R11 valid after reset", 64'(resValid), 64'd0);
    chk(resWrEn == 1'b0, "R11 wren after reset", 64'(resWrEn), 64'd0);
    chk(resData == 64'd0, "R11 data after reset", resData, 64'd0);
  endtask

  task automatic tAfterBasic();
    runCase(0, 1'b0, 32'h0000_0104, 5'd3, "R3 after byte");
    runCase(1, 1'b0, 32'h0000_0011, 5'd4, "R3 after half");
    runCase(2, 1'b0, 32'h0001_0010, 5'd5, "R3 after word");
    runCase(3, 1'b0, 32'h0000_0101, 5'd6, "R3 after dbl");
  endtask

  task automatic tAfterWrap();
    runCase(0, 1'b0, 32'h8000_0001, 5'd7, "R4 wrap byte");
    runCase(1, 1'b0, 32'h4000_0000, 5'd8, "R4 wrap half");
    runCase(3, 1'b0, 32'h0100_0000, 5'd9, "R4 wrap dbl");
  endtask

  task automatic tEmpty();
    runCase(1, 1'b0, 32'h0, 5'd10, "R5 after empty half");
    runCase(3, 1'b0, 32'h0, 5'd11, "R5 after empty dbl");
    runCase(0, 1'b1, 32'h0, 5'd12, "R7 last empty byte");
    runCase(2, 1'b1, 32'h0, 5'd13, "R7 last empty word");
  endtask

  task automatic tLast();
    runCase(0, 1'b1, 32'h0020_0003, 5'd14, "R6 last byte");
    runCase(2, 1'b1, 32'h0000_1101, 5'd15, "R6 last word");
    runCase(3, 1'b1, 32'h0001_0001, 5'd16, "R6 last dbl");
  endtask

  task automatic tLaneRule();
    runCase(1, 1'b1, 32'hAAAA_AAAA, 5'd17, "R2 odd bits ignored half");
    runCase(2, 1'b0, 32'hEEEE_EEE0, 5'd18, "R2 upper bits ignored word");
    runCase(3, 1'b1, 32'h7E00_0001, 5'd19, "R2 upper bits ignored dbl");
  endtask

  task automatic tZeroReg();
    runCase(2, 1'b0, 32'h0000_0100, 5'd31, "R9 zero register");
    runCase(0, 1'b1, 32'h0000_0040, 5'd0, "R9 index zero");
    runCase(1, 1'b0, 32'h0000_0004, 5'd30, "R9 index thirty");
  endtask

  task automatic tBackToBack();
    logic [63:0] e1, e2;
    e1 = model(0, 1'b0, 32'h0000_0002, vecIn);
    e2 = model(3, 1'b1, 32'h0000_0100, vecIn);
    @(negedge clk);
    startValid = 1'b1; sizeCode = 2'd0; pickLast = 1'b0;
    predIn = 32'h0000_0002; destIdx = 5'd20;
    @(negedge clk);
    chk(resData == e1 && resValid, "R10 back to back first", resData, e1);
    sizeCode = 2'd3; pickLast = 1'b1; predIn = 32'h0000_0100; destIdx = 5'd21;
    @(negedge clk);
    startValid = 1'b0;
    chk(resData == e2 && resValid && resDest == 5'd21, "R10 back to back second",
        resData, e2);
    @(negedge clk);
    chk(resValid == 1'b0, "R10 idle after burst", 64'(resValid), 64'd0);
  endtask

  initial begin
    rstN = 1'b0; startValid = 1'b0; sizeCode = '0; pickLast = 1'b0;
    predIn = '0; destIdx = '0;
    for (int b = 0; b < PBITS; b++) vecIn[b*8 +: 8] = 8'(8'h80 + b * 3 + 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAfterBasic();
    tAfterWrap();
    tEmpty();
    tLast();
    tLaneRule();
    tZeroReg();
    tBackToBack();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule